// File: doc/BRIEF.md
# Sensor Region Tagger with Per-Line Dark Clamp

This block sits right behind the converter of a full-frame sensor readout chain. Every digitized sample comes with a 1-based column count within the line and a 1-based row count within the frame. The block labels each sample with the sensor region it belongs to: dummy, internal test, shielded dark, buffer or photoactive. For every line it averages the leading light-shielded columns into a dark level. It then emits only the photoactive samples, and each one is offset-corrected and inverted so that more light gives a larger value.

A higher charge lowers the sensor's output voltage. The corrected value is therefore the dark level minus the raw code, plus a programmable pedestal, and it is clipped to the code range. Column and row layouts are set by parameters. The defaults give 4145 columns by 4128 rows with a 4096 by 4096 photoactive core. A frame-start marker and a line-end marker travel with the image stream. A debug side output carries the region tag of every accepted sample, including those that are not emitted.

Top module: `ccd_dark_clamp`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pix_valid`, `pix_sof`, `pix_eol` and `dbg_tag_valid` are low, and `pix_value` and `dbg_tag` are zero.
- R2: Column class, with default layout: counts 1–11 dummy (tag 0), 12–15 test (tag 1), 16–35 dark (tag 2), 36 buffer (tag 3), 37–4132 active (tag 4), 4133 buffer, 4134–4142 dark, and 4143–4145 and any out-of-range count test. Dummy, test and both dark column groups keep their class on every row.
- R3: Row class, with default layout: row 1 test, rows 2–21 dark, row 22 buffer, rows 23–4118 active, row 4119 buffer, rows 4120–4128 dark, and any other row test. On buffer and active columns, a row class other than active replaces the column class.
- R4: `pix_valid` is high only for samples tagged active (tag 4). Every other sample produces `pix_valid` low and `pix_value` zero.
- R5: The dark level of a line is (S × 3277) >> 16, limited to the maximum code, where S is the sum of that line's 20 samples at counts 16–35. It takes effect from count 36 of the same line. Samples at dummy, test and trailing dark counts never change it.
- R6: An emitted value equals dark level − raw code + PEDESTAL.
- R7: When dark level − raw code + PEDESTAL is negative, the emitted value is 0.
- R8: When dark level − raw code + PEDESTAL exceeds 2^DW − 1, the emitted value is 2^DW − 1.
- R9: `pix_sof` is high with the emitted sample at the first active column of the first active row. `pix_eol` is high with the emitted sample at the last active column of every active row. Both are low at all other times.
- R10: Every output reflects the sample accepted exactly two cycles earlier, and `dbg_tag_valid` follows `smp_valid` with that delay. Idle cycles between samples are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Input sample present |
| smp_code | input | DW | Raw converter code |
| smp_col | input | COL_W | 1-based column count within the line |
| smp_row | input | ROW_W | 1-based row count within the frame |
| pix_valid | output | 1 | Corrected photoactive pixel present |
| pix_value | output | DW | Dark-corrected, inverted, clipped value |
| pix_sof | output | 1 | First pixel of the frame |
| pix_eol | output | 1 | Last pixel of the line |
| dbg_tag_valid | output | 1 | Tag output present |
| dbg_tag | output | 3 | Region tag of the sample |

## Verification
The bench feeds dummy and test columns with extreme codes. A design that folds them into the dark sum then shows value errors across the whole image. Some lines carry dark levels near full scale and raw codes near zero, and others do the reverse. Both clip limits are therefore hit often, so an adder that wraps instead of clipping shows up at once. The bench checks tags on the buffer rows and columns, on the single test row and on the dark rows, because an off-by-one layout either leaks a buffer pixel into the image or drops the first or last active column. Random idle gaps test that the dark level is held between lines and that the two-cycle latency does not depend on how densely samples arrive.

// File: rtl/ccd_clamp_pkg.sv
package ccd_clamp_pkg;
  typedef enum logic [2:0] {
    TAG_DUMMY  = 3'd0,
    TAG_TEST   = 3'd1,
    TAG_DARK   = 3'd2,
    TAG_BUFFER = 3'd3,
    TAG_ACTIVE = 3'd4
  } region_t;

  localparam int RECIP_SHIFT = 16;
endpackage

// File: rtl/region_classifier.sv
module region_classifier
  import ccd_clamp_pkg::*;
#(
  parameter int DUMMY_N       = 11,
  parameter int TEST_N        = 4,
  parameter int DARK_N        = 20,
  parameter int BUF_N         = 1,
  parameter int ACT_W         = 4096,
  parameter int TRAIL_DARK_N  = 9,
  parameter int TRAIL_TEST_N  = 3,
  parameter int TEST_ROWS     = 1,
  parameter int TOP_DARK_ROWS = 20,
  parameter int ACT_H         = 4096,
  parameter int BOT_DARK_ROWS = 9,
  parameter int COL_W         = 13,
  parameter int ROW_W         = 13
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output region_t          tag,
  output logic             dark_ref,
  output logic             dark_first,
  output logic             dark_last,
  output logic             first_px,
  output logic             last_px
);
  // column boundaries (inclusive upper ends)
  localparam int C_DUM_HI  = DUMMY_N;
  localparam int C_TST_HI  = C_DUM_HI + TEST_N;
  localparam int C_DRK_LO  = C_TST_HI + 1;
  localparam int C_DRK_HI  = C_TST_HI + DARK_N;
  localparam int C_LBF_HI  = C_DRK_HI + BUF_N;
  localparam int C_ACT_LO  = C_LBF_HI + 1;
  localparam int C_ACT_HI  = C_LBF_HI + ACT_W;
  localparam int C_RBF_HI  = C_ACT_HI + BUF_N;
  localparam int C_TDK_HI  = C_RBF_HI + TRAIL_DARK_N;
  // row boundaries
  localparam int R_TST_HI  = TEST_ROWS;
  localparam int R_DRK_HI  = R_TST_HI + TOP_DARK_ROWS;
  localparam int R_TBF_HI  = R_DRK_HI + BUF_N;
  localparam int R_ACT_LO  = R_TBF_HI + 1;
  localparam int R_ACT_HI  = R_TBF_HI + ACT_H;
  localparam int R_BBF_HI  = R_ACT_HI + BUF_N;
  localparam int R_BDK_HI  = R_BBF_HI + BOT_DARK_ROWS;

  int      c, r;
  region_t col_cls, row_cls;

  always_comb begin
    c = int'(col);
    r = int'(row);

    if (c < 1)              col_cls = TAG_TEST;
    else if (c <= C_DUM_HI) col_cls = TAG_DUMMY;
    else if (c <= C_TST_HI) col_cls = TAG_TEST;
    else if (c <= C_DRK_HI) col_cls = TAG_DARK;
    else if (c <= C_LBF_HI) col_cls = TAG_BUFFER;
    else if (c <= C_ACT_HI) col_cls = TAG_ACTIVE;
    else if (c <= C_RBF_HI) col_cls = TAG_BUFFER;
    else if (c <= C_TDK_HI) col_cls = TAG_DARK;
    else                    col_cls = TAG_TEST;

    if (r < 1)              row_cls = TAG_TEST;
    else if (r <= R_TST_HI) row_cls = TAG_TEST;
    else if (r <= R_DRK_HI) row_cls = TAG_DARK;
    else if (r <= R_TBF_HI) row_cls = TAG_BUFFER;
    else if (r <= R_ACT_HI) row_cls = TAG_ACTIVE;
    else if (r <= R_BBF_HI) row_cls = TAG_BUFFER;
    else if (r <= R_BDK_HI) row_cls = TAG_DARK;
    else                    row_cls = TAG_TEST;

    // image columns inherit the row class unless the row is active
    if ((col_cls == TAG_BUFFER || col_cls == TAG_ACTIVE) && row_cls != TAG_ACTIVE)
      tag = row_cls;
    else
      tag = col_cls;

    dark_ref   = (c >= C_DRK_LO) && (c <= C_DRK_HI);
    dark_first = (c == C_DRK_LO);
    dark_last  = (c == C_DRK_HI);
    first_px   = (c == C_ACT_LO) && (r == R_ACT_LO);
    last_px    = (c == C_ACT_HI) && (row_cls == TAG_ACTIVE);
  end
endmodule

// File: rtl/dark_estimator.sv
module dark_estimator
  import ccd_clamp_pkg::*;
#(
  parameter int DW     = 12,
  parameter int DARK_N = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          first,
  input  logic          last,
  input  logic [DW-1:0] code,
  output logic [DW-1:0] level
);
  localparam int SUM_W  = DW + $clog2(DARK_N) + 1;
  localparam int PROD_W = SUM_W + RECIP_SHIFT + 1;
  localparam int RECIP  = ((1 << RECIP_SHIFT) + DARK_N / 2) / DARK_N;
  localparam int POW2   = ((DARK_N & (DARK_N - 1)) == 0) ? 1 : 0;
  localparam logic [PROD_W-1:0] MAXV = PROD_W'((1 << DW) - 1);

  logic [SUM_W-1:0]  acc_q, sum_nx;
  logic [PROD_W-1:0] avg;

  assign sum_nx = first ? SUM_W'(code) : acc_q + SUM_W'(code);

  generate
    if (POW2 == 1) begin : g_shift
      assign avg = PROD_W'(sum_nx >> $clog2(DARK_N));
    end else begin : g_recip
      assign avg = (PROD_W'(sum_nx) * PROD_W'(RECIP)) >> RECIP_SHIFT;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      level <= '0;
    end else if (take) begin
      acc_q <= sum_nx;
      if (last) level <= (avg > MAXV) ? DW'(MAXV) : avg[DW-1:0];
    end
  end
endmodule

// File: rtl/clamp_corrector.sv
module clamp_corrector #(
  parameter int DW       = 12,
  parameter int PEDESTAL = 0
) (
  input  logic [DW-1:0] dark,
  input  logic [DW-1:0] code,
  output logic [DW-1:0] value
);
  localparam int MAXI = (1 << DW) - 1;

  logic signed [DW+1:0] diff;

  always_comb begin
    diff = $signed({2'b00, dark}) - $signed({2'b00, code}) + $signed((DW+2)'(PEDESTAL));
    if (diff < 0)
      value = '0;
    else if (diff > $signed((DW+2)'(MAXI)))
      value = DW'(MAXI);
    else
      value = diff[DW-1:0];
  end
endmodule

// File: rtl/ccd_dark_clamp.sv
module ccd_dark_clamp
  import ccd_clamp_pkg::*;
#(
  parameter int DW            = 12,
  parameter int PEDESTAL      = 0,
  parameter int DUMMY_N       = 11,
  parameter int TEST_N        = 4,
  parameter int DARK_N        = 20,
  parameter int BUF_N         = 1,
  parameter int ACT_W         = 4096,
  parameter int TRAIL_DARK_N  = 9,
  parameter int TRAIL_TEST_N  = 3,
  parameter int TEST_ROWS     = 1,
  parameter int TOP_DARK_ROWS = 20,
  parameter int ACT_H         = 4096,
  parameter int BOT_DARK_ROWS = 9,
  parameter int COL_W = $clog2(DUMMY_N + TEST_N + DARK_N + 2*BUF_N + ACT_W
                               + TRAIL_DARK_N + TRAIL_TEST_N + 1),
  parameter int ROW_W = $clog2(TEST_ROWS + TOP_DARK_ROWS + 2*BUF_N + ACT_H
                               + BOT_DARK_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [DW-1:0]    smp_code,
  input  logic [COL_W-1:0] smp_col,
  input  logic [ROW_W-1:0] smp_row,
  output logic             pix_valid,
  output logic [DW-1:0]    pix_value,
  output logic             pix_sof,
  output logic             pix_eol,
  output logic             dbg_tag_valid,
  output logic [2:0]       dbg_tag
);
  region_t cls_tag;
  logic    cls_dref, cls_dfirst, cls_dlast, cls_first, cls_last;

  region_classifier #(
    .DUMMY_N(DUMMY_N), .TEST_N(TEST_N), .DARK_N(DARK_N), .BUF_N(BUF_N),
    .ACT_W(ACT_W), .TRAIL_DARK_N(TRAIL_DARK_N), .TRAIL_TEST_N(TRAIL_TEST_N),
    .TEST_ROWS(TEST_ROWS), .TOP_DARK_ROWS(TOP_DARK_ROWS), .ACT_H(ACT_H),
    .BOT_DARK_ROWS(BOT_DARK_ROWS), .COL_W(COL_W), .ROW_W(ROW_W)
  ) cls_i (
    .col(smp_col), .row(smp_row), .tag(cls_tag), .dark_ref(cls_dref),
    .dark_first(cls_dfirst), .dark_last(cls_dlast),
    .first_px(cls_first), .last_px(cls_last)
  );

  // stage 1: registered sample and its classification
  logic          s1_valid, s1_dref, s1_dfirst, s1_dlast, s1_first, s1_last;
  logic [DW-1:0] s1_code;
  region_t       s1_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_code   <= '0;
      s1_tag    <= TAG_DUMMY;
      s1_dref   <= 1'b0;
      s1_dfirst <= 1'b0;
      s1_dlast  <= 1'b0;
      s1_first  <= 1'b0;
      s1_last   <= 1'b0;
    end else begin
      s1_valid  <= smp_valid;
      s1_code   <= smp_code;
      s1_tag    <= cls_tag;
      s1_dref   <= smp_valid & cls_dref;
      s1_dfirst <= cls_dfirst;
      s1_dlast  <= cls_dlast;
      s1_first  <= cls_first;
      s1_last   <= cls_last;
    end
  end

  logic [DW-1:0] dark_lvl, corr;

  dark_estimator #(.DW(DW), .DARK_N(DARK_N)) est_i (
    .clk(clk), .rst(rst), .take(s1_dref), .first(s1_dfirst),
    .last(s1_dlast), .code(s1_code), .level(dark_lvl)
  );

  clamp_corrector #(.DW(DW), .PEDESTAL(PEDESTAL)) cor_i (
    .dark(dark_lvl), .code(s1_code), .value(corr)
  );

  // stage 2: registered outputs
  logic emit;
  assign emit = s1_valid && (s1_tag == TAG_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid     <= 1'b0;
      pix_value     <= '0;
      pix_sof       <= 1'b0;
      pix_eol       <= 1'b0;
      dbg_tag_valid <= 1'b0;
      dbg_tag       <= 3'd0;
    end else begin
      pix_valid     <= emit;
      pix_value     <= emit ? corr : '0;
      pix_sof       <= emit & s1_first;
      pix_eol       <= emit & s1_last;
      dbg_tag_valid <= s1_valid;
      dbg_tag       <= s1_valid ? s1_tag : TAG_DUMMY;
    end
  end
endmodule

// File: rtl/ccd_dark_clamp_chk.sv
module ccd_dark_clamp_chk #(
  parameter int DUMMY_N = 11,
  parameter int COL_W   = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_valid,
  input logic [COL_W-1:0] smp_col,
  input logic             pix_valid,
  input logic             pix_sof,
  input logic             pix_eol,
  input logic             dbg_tag_valid,
  input logic [2:0]       dbg_tag
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!pix_valid && !dbg_tag_valid && !pix_sof && !pix_eol));

  assert_dummy_tag_R2: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_col >= 1 && int'(smp_col) <= DUMMY_N) |-> ##2 (dbg_tag == 3'd0));

  assert_tag_legal_R2: assert property (@(posedge clk) disable iff (rst)
    dbg_tag_valid |-> (dbg_tag <= 3'd4));

  assert_emit_active_only_R4: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (dbg_tag_valid && dbg_tag == 3'd4));

  assert_markers_in_stream_R9: assert property (@(posedge clk) disable iff (rst)
    (pix_sof || pix_eol) |-> pix_valid);

  assert_latency_on_R10: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> ##2 dbg_tag_valid);

  assert_latency_off_R10: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |-> ##2 !dbg_tag_valid);
endmodule

bind ccd_dark_clamp ccd_dark_clamp_chk #(.DUMMY_N(DUMMY_N), .COL_W(COL_W)) chk_i (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_col(smp_col),
  .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol),
  .dbg_tag_valid(dbg_tag_valid), .dbg_tag(dbg_tag)
);

// File: tb/ccd_dark_clamp_tb_top.sv
module ccd_dark_clamp_tb_top;
  localparam int DW    = 12;
  localparam int PED   = 64;
  localparam int AW    = 16;
  localparam int AH    = 6;
  localparam int NCOL  = 11 + 4 + 20 + 2 + AW + 9 + 3;
  localparam int NROW  = 1 + 20 + 2 + AH + 9;
  localparam int COL_W = $clog2(NCOL + 1);
  localparam int ROW_W = $clog2(NROW + 1);
  localparam int MAXV  = (1 << DW) - 1;

  logic             clk = 1'b0, rst = 1'b1;
  logic             smp_valid = 1'b0;
  logic [DW-1:0]    smp_code = '0;
  logic [COL_W-1:0] smp_col = '0;
  logic [ROW_W-1:0] smp_row = '0;
  logic             pix_valid, pix_sof, pix_eol, dbg_tag_valid;
  logic [DW-1:0]    pix_value;
  logic [2:0]       dbg_tag;

  always #2.5 clk = ~clk;

  ccd_dark_clamp #(.DW(DW), .PEDESTAL(PED), .ACT_W(AW), .ACT_H(AH)) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
    .smp_col(smp_col), .smp_row(smp_row), .pix_valid(pix_valid),
    .pix_value(pix_value), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .dbg_tag_valid(dbg_tag_valid), .dbg_tag(dbg_tag)
  );

  typedef struct {
    bit tv; int tag; bit pv; int val; bit sof; bit eol; bit rowovr;
  } exp_t;

  int   n_run = 0, n_fail = 0;
  exp_t e0, e1;
  int   acc = 0, lvl = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int col_cls(input int c);
    if (c < 1) return 1;
    if (c <= 11) return 0;
    if (c <= 15) return 1;
    if (c <= 35) return 2;
    if (c == 36) return 3;
    if (c <= 36 + AW) return 4;
    if (c == 37 + AW) return 3;
    if (c <= 46 + AW) return 2;
    return 1;
  endfunction

  function automatic int row_cls(input int r);
    if (r < 1) return 1;
    if (r == 1) return 1;
    if (r <= 21) return 2;
    if (r == 22) return 3;
    if (r <= 22 + AH) return 4;
    if (r == 23 + AH) return 3;
    if (r <= 32 + AH) return 2;
    return 1;
  endfunction

  task automatic check_out(input exp_t e);
    chk(dbg_tag_valid == e.tv, "R10", int'(dbg_tag_valid), int'(e.tv));
    if (e.tv) chk(int'(dbg_tag) == e.tag, e.rowovr ? "R3" : "R2", int'(dbg_tag), e.tag);
    chk(pix_valid == e.pv, "R4", int'(pix_valid), int'(e.pv));
    if (e.pv) begin
      if (e.val == 0)         chk(int'(pix_value) == e.val, "R7", int'(pix_value), e.val);
      else if (e.val == MAXV) chk(int'(pix_value) == e.val, "R8", int'(pix_value), e.val);
      else                    chk(int'(pix_value) == e.val, "R5 R6", int'(pix_value), e.val);
    end else chk(pix_value == '0, "R4", int'(pix_value), 0);
    chk(pix_sof == e.sof, "R9", int'(pix_sof), int'(e.sof));
    chk(pix_eol == e.eol, "R9", int'(pix_eol), int'(e.eol));
  endtask

  // one cycle: check the sample from two steps back, then drive a new one
  task automatic step(input bit v, input int c, input int r, input int code);
    int cc, rc, d;
    check_out(e1);
    e1 = e0;
    e0 = '{default: 0};
    if (v) begin
      cc = col_cls(c);
      rc = row_cls(r);
      e0.tv = 1;
      e0.tag = ((cc == 3 || cc == 4) && rc != 4) ? rc : cc;
      e0.rowovr = (cc == 3 || cc == 4) && rc != 4;
      if (c >= 16 && c <= 35) begin
        acc = (c == 16) ? code : acc + code;
        if (c == 35) begin
          lvl = (acc * 3277) >>> 16;
          if (lvl > MAXV) lvl = MAXV;
        end
      end
      if (e0.tag == 4) begin
        e0.pv = 1;
        d = lvl - code + PED;
        e0.val = (d < 0) ? 0 : (d > MAXV) ? MAXV : d;
        e0.sof = (c == 37) && (r == 23);
        e0.eol = (c == 36 + AW);
      end
    end
    smp_valid = v;
    smp_col   = COL_W'(c);
    smp_row   = ROW_W'(r);
    smp_code  = DW'(code);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int pick_code(input int c, input int mode);
    int k;
    if (c <= 15 || c > 46 + AW) return ($urandom % 2) ? MAXV : ($urandom % 8);
    if (c >= 16 && c <= 35) begin
      if (mode == 0) return MAXV - 15 + ($urandom % 16);
      if (mode == 1) return 1000 + ($urandom % 500);
      return $urandom % (MAXV + 1);
    end
    k = $urandom % 4;
    if (k == 0) return $urandom % 40;
    if (k == 1) return MAXV - ($urandom % 40);
    return $urandom % (MAXV + 1);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    e0 = '{default: 0};
    e1 = '{default: 0};
    // R1: reset state, even with a valid sample pending at the input
    smp_valid = 1'b1;
    smp_col = COL_W'(40);
    smp_row = ROW_W'(25);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!pix_valid && !dbg_tag_valid && !pix_sof && !pix_eol, "R1",
        int'(pix_valid) + int'(dbg_tag_valid), 0);
    chk(pix_value == '0 && dbg_tag == 3'd0, "R1", int'(pix_value) + int'(dbg_tag), 0);
    rst = 1'b0;
    smp_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!pix_valid && !dbg_tag_valid, "R1", int'(pix_valid) + int'(dbg_tag_valid), 0);

    // directed line: dark 2000 flat, dummy/test at full scale (R5 exclusion)
    for (int c = 1; c <= NCOL; c++) begin
      int code;
      if (c <= 15) code = MAXV;
      else if (c <= 35) code = 2000;
      else if (c == 37) code = 2000 + PED;
      else code = 1500;
      step(1'b1, c, 23, code);
    end

    // random frames with idle gaps
    for (int f = 0; f < 3; f++) begin
      for (int r = 1; r <= NROW; r++) begin
        int mode;
        mode = $urandom % 3;
        for (int c = 1; c <= NCOL; c++) begin
          while (($urandom % 5) == 0) step(1'b0, $urandom % NCOL, $urandom % NROW, $urandom % 4096);
          step(1'b1, c, r, pick_code(c, mode));
        end
      end
    end

    // out-of-range counts are tagged test and never emitted
    step(1'b1, 0, 25, 100);
    step(1'b1, NCOL + 1, 25, 100);
    step(1'b1, 40, NROW + 1, 100);
    repeat (3) step(1'b0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule